// File: doc/BRIEF.md
# Saturating 64-by-32 Divider

This block is an iterative divider for a processor's integer unit. The dividend is 64 bits wide. Its upper half comes from a dedicated high-word register and its lower half from the low 32 bits of the first source operand. The divisor is 32 bits wide. The operation runs either as unsigned or as two's-complement signed. The quotient must fit in 32 bits; when it does not, the block clamps it to the nearest representable value and raises an overflow flag that the surrounding pipeline can copy into its condition codes. A divisor of zero is reported at once and leaves the destination value untouched.

An operation begins when `start` is sampled high while the unit is idle. The unit takes the magnitudes of both operands and then runs a restoring shift-subtract loop, producing one quotient bit per cycle over 64 cycles. In a final cycle it restores the sign, applies the clamp and extends the value to 64 bits. `busy` stays high for the whole operation, and `done` pulses for one cycle when `result`, `ovf` and `div_zero` become valid. These outputs then hold until the next operation completes.

Top module: `div64x32_sat`

## Requirements
- R1: In unsigned mode (`signed_mode`=0) the dividend is {`y_hi`,`op_lo`} and the divisor is `divisor`, both read as unsigned. When the quotient is below 2^32, `result` holds the quotient zero-extended to 64 bits.
- R2: In signed mode (`signed_mode`=1) both operands are two's complement and the quotient truncates toward zero. When the quotient lies in [-2^31, 2^31-1], `result` holds it sign-extended to 64 bits.
- R3: In unsigned mode a quotient of 2^32 or more gives `result` = 64'h00000000FFFFFFFF with `ovf`=1.
- R4: In signed mode a quotient above 2^31-1 gives `result` = 64'h000000007FFFFFFF with `ovf`=1.
- R5: In signed mode a quotient below -2^31 gives `result` = 64'hFFFFFFFF80000000 with `ovf`=1.
- R6: A start with `divisor`=0 asserts `done` and `div_zero` in the cycle after the start edge. It leaves `result` at its previous value, and `ovf` reads 0.
- R7: A nonzero-divisor operation holds `busy` high from the start edge, and `done` goes high for exactly one cycle, 65 clock edges after the start edge. `busy` is low whenever `done` is high.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The running operation completes with its own operands and keeps its timing.
- R9: After reset `busy`, `done`, `div_zero` and `ovf` are 0 and `result` is 0.
- R10: `ovf` is 0 and `div_zero` is 0 for every operation whose quotient fits its mode's range, including the exact boundaries 2^32-1 (unsigned) and -2^31 (signed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| signed_mode | input | 1 | 1 = two's-complement divide, 0 = unsigned |
| y_hi | input | 32 | Upper half of the dividend |
| op_lo | input | 32 | Lower half of the dividend |
| divisor | input | 32 | Divisor (register value or extended immediate) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Last operation had a zero divisor |
| ovf | output | 1 | Last quotient was clamped |
| result | output | 64 | Destination value |

## Verification
The embedded assertions check properties that must hold on every cycle. `done` lasts one cycle and never coincides with `busy`. A zero divisor completes on the next edge without changing `result` or raising `ovf`. An unsigned `result` always has a zero upper word, an unsigned clamp always carries the all-ones low word, and a signed `result` is always a valid sign extension of a 32-bit value. Whether the quotient is numerically right, which clamp a given sign combination selects, the exact 65-edge latency and the rejection of a start during an operation can only be shown by the bench's operand scenarios.

// File: rtl/div64x32_sat.sv
module div64x32_sat #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           signed_mode,
  input  logic [W-1:0]   y_hi,
  input  logic [W-1:0]   op_lo,
  input  logic [W-1:0]   divisor,
  output logic           busy,
  output logic           done,
  output logic           div_zero,
  output logic           ovf,
  output logic [2*W-1:0] result
);
  localparam int DW    = 2 * W;
  localparam int ITER  = DW;
  localparam int CW    = $clog2(ITER + 1);
  localparam logic [CW-1:0] LAST = CW'(ITER);

  logic          sgn_q, neg_q;
  logic [CW-1:0] cnt;
  logic [W-1:0]  dvs, rem;
  logic [DW-1:0] quo;

  logic [DW-1:0] dividend, a_mag;
  logic [W-1:0]  b_mag;
  logic          a_neg, b_neg;

  assign dividend = {y_hi, op_lo};
  assign a_neg    = signed_mode & dividend[DW-1];
  assign b_neg    = signed_mode & divisor[W-1];
  assign a_mag    = a_neg ? (~dividend + 1'b1) : dividend;
  assign b_mag    = b_neg ? (~divisor + 1'b1) : divisor;

  logic [W:0]   trial, diff;
  logic         take;
  assign trial = {rem, quo[DW-1]};
  assign diff  = trial - {1'b0, dvs};
  assign take  = ~diff[W];

  logic          hi_nz, u_ovf, s_pos, s_neg;
  logic [W-1:0]  q_lo;
  logic [DW-1:0] fin;
  assign hi_nz = |quo[DW-1:W];
  assign u_ovf = hi_nz;
  assign s_pos = ~neg_q & (hi_nz | quo[W-1]);
  assign s_neg = neg_q & (hi_nz | (quo[W-1] & (|quo[W-2:0])));
  assign q_lo  = neg_q ? (~quo[W-1:0] + 1'b1) : quo[W-1:0];

  always_comb begin
    if (!sgn_q)
      fin = u_ovf ? {{W{1'b0}}, {W{1'b1}}} : {{W{1'b0}}, quo[W-1:0]};
    else if (s_pos)
      fin = {{(W+1){1'b0}}, {(W-1){1'b1}}};
    else if (s_neg)
      fin = {{(W+1){1'b1}}, {(W-1){1'b0}}};
    else
      fin = {{W{q_lo[W-1]}}, q_lo};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; div_zero <= 1'b0; ovf <= 1'b0;
      result <= '0; sgn_q <= 1'b0; neg_q <= 1'b0; cnt <= '0;
      dvs <= '0; rem <= '0; quo <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          sgn_q <= signed_mode;
          if (divisor == '0) begin
            done     <= 1'b1;
            div_zero <= 1'b1;
            ovf      <= 1'b0;
          end else begin
            busy  <= 1'b1;
            neg_q <= a_neg ^ b_neg;
            dvs   <= b_mag;
            rem   <= '0;
            quo   <= a_mag;
            cnt   <= '0;
          end
        end
      end else if (cnt != LAST) begin
        rem <= take ? diff[W-1:0] : trial[W-1:0];
        quo <= {quo[DW-2:0], take};
        cnt <= cnt + 1'b1;
      end else begin
        busy     <= 1'b0;
        done     <= 1'b1;
        div_zero <= 1'b0;
        result   <= fin;
        ovf      <= sgn_q ? (s_pos | s_neg) : u_ovf;
      end
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_zero_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor == '0) |=> (done && div_zero));
  p_zero_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_zero) |-> ($stable(result) && !ovf));
  p_usat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero && !sgn_q && ovf) |-> result == {{W{1'b0}}, {W{1'b1}}});
  p_uzext_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero && !sgn_q) |-> result[DW-1:W] == '0);
  p_srange_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero && sgn_q) |-> (result[DW-1:W-1] == '0 || (&result[DW-1:W-1])));
  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || (done && !div_zero)));
endmodule

// File: tb/div64x32_sat_bench.sv
module div64x32_sat_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // {signed, y_hi, op_lo, divisor, expected result, expected ovf}
  localparam logic [161:0] VEC [NV] = '{
    {1'b0, 32'h00000000, 32'h00000064, 32'h00000007, 64'h000000000000000E, 1'b0},
    {1'b0, 32'h00000001, 32'h00000000, 32'h00000002, 64'h0000000080000000, 1'b0},
    {1'b0, 32'h00000001, 32'h00000000, 32'h00000001, 64'h00000000FFFFFFFF, 1'b1},
    {1'b0, 32'h00000000, 32'hFFFFFFFF, 32'h00000001, 64'h00000000FFFFFFFF, 1'b0},
    {1'b0, 32'h00000000, 32'hFFFFFFF9, 32'h00000002, 64'h000000007FFFFFFC, 1'b0},
    {1'b1, 32'h00000000, 32'h00000064, 32'hFFFFFFF9, 64'hFFFFFFFFFFFFFFF2, 1'b0},
    {1'b1, 32'hFFFFFFFF, 32'hFFFFFF9C, 32'h00000007, 64'hFFFFFFFFFFFFFFF2, 1'b0},
    {1'b1, 32'hFFFFFFFF, 32'hFFFFFF9C, 32'hFFFFFFF9, 64'h000000000000000E, 1'b0},
    {1'b1, 32'h00000000, 32'h00000007, 32'h00000002, 64'h0000000000000003, 1'b0},
    {1'b1, 32'hFFFFFFFF, 32'hFFFFFFF9, 32'h00000002, 64'hFFFFFFFFFFFFFFFD, 1'b0},
    {1'b1, 32'h00000000, 32'h80000000, 32'h00000001, 64'h000000007FFFFFFF, 1'b1},
    {1'b1, 32'h80000000, 32'h00000000, 32'hFFFFFFFF, 64'h000000007FFFFFFF, 1'b1},
    {1'b1, 32'h00000000, 32'h80000000, 32'hFFFFFFFF, 64'hFFFFFFFF80000000, 1'b0},
    {1'b1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h00000001, 64'hFFFFFFFF80000000, 1'b1}
  };
  // requirement tag per vector
  localparam string TAGS [NV] = '{"R1", "R1", "R3", "R10", "R1", "R2", "R2",
                                  "R2", "R2", "R2", "R4", "R4", "R10", "R5"};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, signed_mode = 1'b0;
  logic [31:0] y_hi = '0, op_lo = '0, divisor = '0;
  logic busy, done, div_zero, ovf;
  logic [63:0] result;
  int total = 0, bad = 0, cyc = 0, lat;

  div64x32_sat u_div64x32_sat (.clk(clk), .rst_n(rst_n), .start(start),
    .signed_mode(signed_mode), .y_hi(y_hi), .op_lo(op_lo), .divisor(divisor),
    .busy(busy), .done(done), .div_zero(div_zero), .ovf(ovf), .result(result));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic s, input logic [31:0] h, input logic [31:0] l,
                        input logic [31:0] d);
    @(negedge clk);
    signed_mode = s; y_hi = h; op_lo = l; divisor = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    while (!done && k < 300) begin
      @(negedge clk);
      k = k + 1;
    end
  endtask

  initial begin
    logic [63:0] prev;
    #(CLK_PERIOD * 3);
    chk("R9 busy", 64'(busy), 64'd0);
    chk("R9 done", 64'(done), 64'd0);
    chk("R9 result", result, 64'd0);
    chk("R9 flags", {62'd0, ovf, div_zero}, 64'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      launch(VEC[i][161], VEC[i][160:129], VEC[i][128:97], VEC[i][96:65]);
      chk("R7 busy after start", 64'(busy), 64'd1);
      wait_done(lat);
      chk({TAGS[i], " result"}, result, VEC[i][64:1]);
      chk({TAGS[i], " ovf"}, 64'(ovf), 64'(VEC[i][0]));
      chk("R10 div_zero low", 64'(div_zero), 64'd0);
      chk("R7 latency", 64'(lat), 64'd65);
      chk("R7 busy low at done", 64'(busy), 64'd0);
      @(negedge clk);
      chk("R7 done one cycle", 64'(done), 64'd0);
    end

    // R6: zero divisor keeps result, flags at once
    prev = result;
    launch(1'b0, 32'h12345678, 32'h9ABCDEF0, 32'h0);
    chk("R6 done next cycle", 64'(done), 64'd1);
    chk("R6 div_zero", 64'(div_zero), 64'd1);
    chk("R6 ovf low", 64'(ovf), 64'd0);
    chk("R6 result kept", result, prev);
    chk("R6 not busy", 64'(busy), 64'd0);
    @(negedge clk);
    chk("R6 done one cycle", 64'(done), 64'd0);
    chk("R6 result still kept", result, prev);

    // R8: start during busy ignored
    launch(1'b0, 32'h00000000, 32'h000003E8, 32'h0000000A);
    repeat (10) @(negedge clk);
    signed_mode = 1'b1; y_hi = 32'hFFFFFFFF; op_lo = 32'hFFFFFF00; divisor = 32'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 still busy", 64'(busy), 64'd1);
    chk("R8 no early done", 64'(done), 64'd0);
    wait_done(lat);
    chk("R8 latency kept", 64'(lat + 11), 64'd65);
    chk("R8 first operands", result, 64'h0000000000000064);
    chk("R8 flags", {62'd0, ovf, div_zero}, 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule